// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which earlier store a load (or store) must wait for in an out-of-order core. It keeps two tables. The set-ID table is indexed by instruction address and names, per entry, the store set that instruction belongs to. The last-store table holds, per set, the sequence number of the youngest store of that set fetched so far and not yet issued or squashed. When a load and store are caught violating memory order, the training port puts both instructions into one set. Every fetched store refreshes its set's last-store entry. A newly fetched instruction looks up the sequence number it must wait behind; zero means no dependence.

Issue of a store retires its own last-store entry. A squash removes every recorded store younger than the squash point. A global clear forgets everything. Table sizes are powers of two. Lookup is combinational on the registered tables. All updates land on the next clock edge.

Top module: `ssp_top`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `lkp_seq` is 0 for every PC. `clr` overrides any request made in the same cycle.
- R2: The set-ID table entry is selected by PC bits [IDX_W+1:2], which are bits [7:2] for the default 64 entries. PCs that differ only in bits [1:0] or above bit 7 share an entry.
- R3: Training where neither PC has a valid set ID assigns both the ID load PC bits [SET_W+1:2] (bits [5:2] by default) and marks both valid.
- R4: Training where exactly one PC has a valid set ID copies that ID into the other entry and marks it valid.
- R5: Training where both PCs have valid IDs rewrites the entry holding the larger ID with the smaller one. The entry already holding the smaller ID and all other entries are unchanged.
- R6: A fetched store whose PC has a valid set ID records its sequence number in that set and marks it valid. A fetched store with no valid ID changes nothing.
- R7: `lkp_seq` is combinational. It is 0 when the PC has no valid ID or its set has no valid last store; otherwise it is the recorded sequence number.
- R8: An issue with `iss_is_store` high clears the set's last-store entry only when the recorded number equals `iss_seq`. An issue with `iss_is_store` low has no effect.
- R9: A squash invalidates every last-store entry whose number is strictly greater than `sq_seq`. Entries equal to or below it stay.
- R10: A fetched store in the same cycle as training reads the set ID as it was before that training. A fetched store's write to a set wins over a same-cycle issue or squash of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate both tables |
| trn_valid | input | 1 | Violation training request |
| trn_load_pc | input | PC_W | PC of the violating load |
| trn_store_pc | input | PC_W | PC of the violated store |
| fst_valid | input | 1 | A store has been fetched |
| fst_pc | input | PC_W | PC of the fetched store |
| fst_seq | input | SEQ_W | Sequence number of the fetched store |
| lkp_pc | input | PC_W | PC of the instruction being looked up |
| lkp_seq | output | SEQ_W | Sequence number to wait for, 0 if none |
| iss_valid | input | 1 | An instruction has issued |
| iss_is_store | input | 1 | The issued instruction is a store |
| iss_pc | input | PC_W | PC of the issued instruction |
| iss_seq | input | SEQ_W | Sequence number of the issued instruction |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point; younger stores are dropped |

## Verification
The assertions assume that sequence numbers grow without wrapping, so "younger" is a plain unsigned greater-than. They also treat an idle cycle as one with no training, no fetched store, no store issue, no squash and no clear, and assume the lookup PC is held if the result is to be compared. The bench drives only small, increasing sequence numbers and changes the lookup PC only at falling edges. It always gives the squash point as a number at or below the stores that must survive.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // How a violation is folded into the set-ID table
    typedef enum logic [1:0] {
        TRAIN_FRESH,       // neither side owns a set: open one
        TRAIN_STORE_JOINS, // only the load owns a set
        TRAIN_LOAD_JOINS,  // only the store owns a set
        TRAIN_MERGE        // both own a set: smaller ID survives
    } train_kind_e;

    function automatic train_kind_e train_kind(input logic load_known, input logic store_known);
        if (!load_known && !store_known) return TRAIN_FRESH;
        if (load_known && !store_known)  return TRAIN_STORE_JOINS;
        if (!load_known && store_known)  return TRAIN_LOAD_JOINS;
        return TRAIN_MERGE;
    endfunction

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table
    import ssp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ID_W  = 4,
    parameter int N_RD  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        trn_valid,
    input  logic [IDX_W-1:0]            trn_load_idx,
    input  logic [IDX_W-1:0]            trn_store_idx,
    input  logic [ID_W-1:0]             trn_new_id,
    input  logic [N_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [N_RD-1:0]             rd_vld,
    output logic [N_RD-1:0][ID_W-1:0]   rd_id
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][ID_W-1:0] id;
    } tbl_t;

    tbl_t st_d, st_q;

    logic            load_known, store_known;
    logic [ID_W-1:0] load_id, store_id;

    assign load_known  = st_q.vld[trn_load_idx];
    assign store_known = st_q.vld[trn_store_idx];
    assign load_id     = st_q.id[trn_load_idx];
    assign store_id    = st_q.id[trn_store_idx];

    always_comb begin
        st_d = st_q;
        if (trn_valid) begin
            unique case (train_kind(load_known, store_known))
                TRAIN_FRESH: begin
                    st_d.vld[trn_load_idx]  = 1'b1;
                    st_d.id[trn_load_idx]   = trn_new_id;
                    st_d.vld[trn_store_idx] = 1'b1;
                    st_d.id[trn_store_idx]  = trn_new_id;
                end
                TRAIN_STORE_JOINS: begin
                    st_d.vld[trn_store_idx] = 1'b1;
                    st_d.id[trn_store_idx]  = load_id;
                end
                TRAIN_LOAD_JOINS: begin
                    st_d.vld[trn_load_idx]  = 1'b1;
                    st_d.id[trn_load_idx]   = store_id;
                end
                TRAIN_MERGE: begin
                    if (store_id > load_id) st_d.id[trn_store_idx] = load_id;
                    else                    st_d.id[trn_load_idx]  = store_id;
                end
                default: ;
            endcase
        end
        if (clr) st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_vld[g] = st_q.vld[rd_idx[g]];
        assign rd_id[g]  = st_q.id[rd_idx[g]];
    end

endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
    parameter int SET_W = 4,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ins_en,
    input  logic [SET_W-1:0] ins_set,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             iss_en,
    input  logic [SET_W-1:0] iss_set,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             sq_en,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_vld,
    output logic [SEQ_W-1:0] rd_seq
);

    localparam int SETS = 1 << SET_W;

    typedef struct packed {
        logic [SETS-1:0]            vld;
        logic [SETS-1:0][SEQ_W-1:0] seq;
    } lst_t;

    lst_t st_d, st_q;

    logic [SETS-1:0] sq_kill;
    logic            iss_hit;

    for (genvar g = 0; g < SETS; g++) begin : g_sq
        assign sq_kill[g] = sq_en && st_q.vld[g] && (st_q.seq[g] > sq_seq);
    end

    assign iss_hit = iss_en && st_q.vld[iss_set] && (st_q.seq[iss_set] == iss_seq);

    // Order of application: issue, squash, fetched store, clear
    always_comb begin
        st_d = st_q;
        if (iss_hit) st_d.vld[iss_set] = 1'b0;
        st_d.vld = st_d.vld & ~sq_kill;
        if (ins_en) begin
            st_d.vld[ins_set] = 1'b1;
            st_d.seq[ins_set] = ins_seq;
        end
        if (clr) st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld = st_q.vld[rd_set];
    assign rd_seq = st_q.seq[rd_set];

endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
    parameter int PC_W        = 32,
    parameter int SEQ_W       = 16,
    parameter int ID_ENTRIES  = 64,
    parameter int SET_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             trn_valid,
    input  logic [PC_W-1:0]  trn_load_pc,
    input  logic [PC_W-1:0]  trn_store_pc,
    input  logic             fst_valid,
    input  logic [PC_W-1:0]  fst_pc,
    input  logic [SEQ_W-1:0] fst_seq,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic [SEQ_W-1:0] lkp_seq,
    input  logic             iss_valid,
    input  logic             iss_is_store,
    input  logic [PC_W-1:0]  iss_pc,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq
);

    localparam int IDX_W = $clog2(ID_ENTRIES);
    localparam int SET_W = $clog2(SET_ENTRIES);
    localparam int N_RD  = 3;
    localparam int RD_FST = 0;
    localparam int RD_ISS = 1;
    localparam int RD_LKP = 2;

    if ((1 << IDX_W) != ID_ENTRIES || (1 << SET_W) != SET_ENTRIES) begin : g_bad_size
        $error("table sizes must be powers of two");
    end

    logic [N_RD-1:0][IDX_W-1:0] rd_idx;
    logic [N_RD-1:0]            rd_vld;
    logic [N_RD-1:0][SET_W-1:0] rd_id;
    logic                       ls_vld;
    logic [SEQ_W-1:0]           ls_seq;

    assign rd_idx[RD_FST] = fst_pc[IDX_W+1:2];
    assign rd_idx[RD_ISS] = iss_pc[IDX_W+1:2];
    assign rd_idx[RD_LKP] = lkp_pc[IDX_W+1:2];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{trn_load_pc[PC_W-1:IDX_W+2], trn_load_pc[1:0],
                              trn_store_pc[PC_W-1:IDX_W+2], trn_store_pc[1:0],
                              fst_pc[PC_W-1:IDX_W+2], fst_pc[1:0],
                              iss_pc[PC_W-1:IDX_W+2], iss_pc[1:0],
                              lkp_pc[PC_W-1:IDX_W+2], lkp_pc[1:0]};

    ssp_id_table #(
        .IDX_W (IDX_W),
        .ID_W  (SET_W),
        .N_RD  (N_RD)
    ) u_ids (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (clr),
        .trn_valid     (trn_valid),
        .trn_load_idx  (trn_load_pc[IDX_W+1:2]),
        .trn_store_idx (trn_store_pc[IDX_W+1:2]),
        .trn_new_id    (trn_load_pc[SET_W+1:2]),
        .rd_idx        (rd_idx),
        .rd_vld        (rd_vld),
        .rd_id         (rd_id)
    );

    ssp_last_store #(
        .SET_W (SET_W),
        .SEQ_W (SEQ_W)
    ) u_lst (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ins_en  (fst_valid && rd_vld[RD_FST]),
        .ins_set (rd_id[RD_FST]),
        .ins_seq (fst_seq),
        .iss_en  (iss_valid && iss_is_store && rd_vld[RD_ISS]),
        .iss_set (rd_id[RD_ISS]),
        .iss_seq (iss_seq),
        .sq_en   (sq_valid),
        .sq_seq  (sq_seq),
        .rd_set  (rd_id[RD_LKP]),
        .rd_vld  (ls_vld),
        .rd_seq  (ls_seq)
    );

    assign lkp_seq = (rd_vld[RD_LKP] && ls_vld) ? ls_seq : '0;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             trn_valid,
    input logic             fst_valid,
    input logic [PC_W-1:0]  fst_pc,
    input logic [SEQ_W-1:0] fst_seq,
    input logic [PC_W-1:0]  lkp_pc,
    input logic [SEQ_W-1:0] lkp_seq,
    input logic             iss_valid,
    input logic             iss_is_store,
    input logic             sq_valid,
    input logic [SEQ_W-1:0] sq_seq
);

    logic quiet;
    assign quiet = !trn_valid && !fst_valid && !(iss_valid && iss_is_store) && !sq_valid && !clr;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lkp_seq == '0); // R1

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> lkp_seq == '0); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> (lkp_pc != $past(lkp_pc)) || (lkp_seq == $past(lkp_seq))); // R8

    AST_SQUASH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !fst_valid) |=> (lkp_seq == '0) || (lkp_seq <= $past(sq_seq))); // R9

    AST_FETCH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fst_valid && !clr && !trn_valid && lkp_pc == fst_pc) |=>
            (lkp_pc != $past(lkp_pc)) || (lkp_seq == '0) || (lkp_seq == $past(fst_seq))); // R6

endmodule

bind ssp_top ssp_checker #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/tb_ssp_top.sv
`timescale 1ns/1ps
module tb_ssp_top;

    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr, trn_valid, fst_valid, iss_valid, iss_is_store, sq_valid;
    logic [PC_W-1:0]  trn_load_pc, trn_store_pc, fst_pc, lkp_pc, iss_pc;
    logic [SEQ_W-1:0] fst_seq, iss_seq, sq_seq, lkp_seq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ssp_top #(.PC_W(PC_W), .SEQ_W(SEQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .trn_valid(trn_valid), .trn_load_pc(trn_load_pc), .trn_store_pc(trn_store_pc),
        .fst_valid(fst_valid), .fst_pc(fst_pc), .fst_seq(fst_seq),
        .lkp_pc(lkp_pc), .lkp_seq(lkp_seq),
        .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_pc(iss_pc), .iss_seq(iss_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq)
    );

    localparam logic [2:0] OP_LK = 3'd0, OP_TRN = 3'd1, OP_FST = 3'd2, OP_ISS = 3'd3,
                           OP_ISN = 3'd4, OP_SQ = 3'd5, OP_CLR = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [15:0] a;   // PC
        logic [15:0] b;   // store PC or sequence number
        logic [15:0] exp; // expected lookup result
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{OP_LK,  4'd1, 16'h000C, 16'd0,     16'd0},  // R1 empty after reset
        '{OP_TRN, 4'd3, 16'h000C, 16'h0028,  16'd0},  // R3 fresh set 3
        '{OP_FST, 4'd6, 16'h0028, 16'd5,     16'd0},  // R6
        '{OP_LK,  4'd3, 16'h000C, 16'd0,     16'd5},  // R3 load shares set
        '{OP_LK,  4'd6, 16'h0028, 16'd0,     16'd5},  // R6
        '{OP_FST, 4'd6, 16'h0030, 16'd9,     16'd0},  // R6 no ID: ignored
        '{OP_LK,  4'd7, 16'h0030, 16'd0,     16'd0},  // R7 no ID
        '{OP_LK,  4'd6, 16'h000C, 16'd0,     16'd5},  // R6 unchanged
        '{OP_ISN, 4'd8, 16'h0028, 16'd5,     16'd0},  // R8 non-store issue
        '{OP_LK,  4'd8, 16'h000C, 16'd0,     16'd5},  // R8
        '{OP_ISS, 4'd8, 16'h0028, 16'd4,     16'd0},  // R8 mismatched number
        '{OP_LK,  4'd8, 16'h000C, 16'd0,     16'd5},  // R8
        '{OP_ISS, 4'd8, 16'h0028, 16'd5,     16'd0},  // R8 matching number
        '{OP_LK,  4'd8, 16'h000C, 16'd0,     16'd0},  // R8 cleared
        '{OP_TRN, 4'd4, 16'h0014, 16'h0028,  16'd0},  // R4 load joins set 3
        '{OP_FST, 4'd4, 16'h0028, 16'd20,    16'd0},  // R4
        '{OP_LK,  4'd4, 16'h0014, 16'd0,     16'd20}, // R4
        '{OP_LK,  4'd2, 16'h0117, 16'd0,     16'd20}, // R2 alias of 0x14
        '{OP_TRN, 4'd3, 16'h0004, 16'h0040,  16'd0},  // R3 fresh set 1
        '{OP_TRN, 4'd5, 16'h0014, 16'h0040,  16'd0},  // R5 store ID smaller
        '{OP_FST, 4'd5, 16'h0040, 16'd30,    16'd0},  // R5
        '{OP_LK,  4'd5, 16'h0014, 16'd0,     16'd30}, // R5 load moved to set 1
        '{OP_LK,  4'd5, 16'h000C, 16'd0,     16'd20}, // R5 set 3 untouched
        '{OP_TRN, 4'd5, 16'h0004, 16'h0028,  16'd0},  // R5 load ID smaller
        '{OP_FST, 4'd5, 16'h0028, 16'd40,    16'd0},  // R5
        '{OP_LK,  4'd5, 16'h0004, 16'd0,     16'd40}, // R5 store moved to set 1
        '{OP_LK,  4'd5, 16'h000C, 16'd0,     16'd20}, // R5
        '{OP_SQ,  4'd9, 16'h0000, 16'd20,    16'd0},  // R9 squash above 20
        '{OP_LK,  4'd9, 16'h0004, 16'd0,     16'd0},  // R9 40 dropped
        '{OP_LK,  4'd9, 16'h000C, 16'd0,     16'd20}, // R9 equal kept
        '{OP_CLR, 4'd1, 16'h0000, 16'd0,     16'd0},  // R1
        '{OP_LK,  4'd1, 16'h000C, 16'd0,     16'd0},  // R1
        '{OP_FST, 4'd1, 16'h000C, 16'd7,     16'd0},  // R1 IDs gone
        '{OP_LK,  4'd1, 16'h000C, 16'd0,     16'd0}   // R1
    };

    task automatic idle();
        clr = 0; trn_valid = 0; fst_valid = 0; iss_valid = 0; iss_is_store = 0; sq_valid = 0;
    endtask

    task automatic check(input string tag, input logic [SEQ_W-1:0] act, input logic [SEQ_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic [PC_W-1:0] pc, input logic [SEQ_W-1:0] exp);
        @(negedge clk);
        idle();
        lkp_pc = pc;
        #1 check(tag, lkp_seq, exp);
    endtask

    task automatic put_fst(input logic [PC_W-1:0] pc, input logic [SEQ_W-1:0] seq);
        fst_valid = 1; fst_pc = pc; fst_seq = seq;
    endtask

    initial begin
        idle();
        trn_load_pc = '0; trn_store_pc = '0; fst_pc = '0; lkp_pc = '0;
        iss_pc = '0; fst_seq = '0; iss_seq = '0; sq_seq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            case (VECS[i].op)
                OP_LK:  begin
                    lkp_pc = PC_W'(VECS[i].a);
                    #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), lkp_seq, VECS[i].exp);
                end
                OP_TRN: begin trn_valid = 1; trn_load_pc = PC_W'(VECS[i].a); trn_store_pc = PC_W'(VECS[i].b); end
                OP_FST: put_fst(PC_W'(VECS[i].a), VECS[i].b);
                OP_ISS: begin iss_valid = 1; iss_is_store = 1; iss_pc = PC_W'(VECS[i].a); iss_seq = VECS[i].b; end
                OP_ISN: begin iss_valid = 1; iss_is_store = 0; iss_pc = PC_W'(VECS[i].a); iss_seq = VECS[i].b; end
                OP_SQ:  begin sq_valid = 1; sq_seq = VECS[i].b; end
                OP_CLR: clr = 1;
                default: ;
            endcase
        end

        // R10: fetch in the training cycle sees the old (empty) ID
        @(negedge clk); idle();
        trn_valid = 1; trn_load_pc = 32'h0C; trn_store_pc = 32'h28;
        put_fst(32'h28, 16'd50);
        look("R10 fetch during training", 32'h0C, 16'd0);
        @(negedge clk); idle(); put_fst(32'h28, 16'd51);
        look("R3 set usable after training", 32'h0C, 16'd51);

        // R10: fetch wins over same-cycle matching issue
        @(negedge clk); idle(); put_fst(32'h28, 16'd60);
        iss_valid = 1; iss_is_store = 1; iss_pc = 32'h28; iss_seq = 16'd51;
        look("R10 fetch beats issue", 32'h0C, 16'd60);

        // R10: fetch wins over same-cycle squash
        @(negedge clk); idle(); put_fst(32'h28, 16'd70);
        sq_valid = 1; sq_seq = 16'd10;
        look("R10 fetch beats squash", 32'h0C, 16'd70);

        // R1: clear beats same-cycle fetch
        @(negedge clk); idle(); put_fst(32'h28, 16'd80); clr = 1;
        look("R1 clear beats fetch", 32'h0C, 16'd0);

        // R1: reset in mid-run
        @(negedge clk); idle(); trn_valid = 1; trn_load_pc = 32'h0C; trn_store_pc = 32'h28;
        @(negedge clk); idle(); put_fst(32'h28, 16'd90);
        look("R6 before reset", 32'h0C, 16'd90);
        @(negedge clk); idle(); rst_n = 0;
        #1 check("R1 during reset", lkp_seq, 16'd0);
        @(negedge clk); rst_n = 1;
        look("R1 after reset", 32'h0C, 16'd0);

        @(negedge clk); idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog for all requirements actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule